// File: doc/BRIEF.md
# Prefixed-Opcode Bit and Shift Execution Unit

This unit executes the second byte of an escape-prefixed instruction on one 8-bit operand. The opcode byte is split into three fields: the top two bits pick the operation group, the middle three bits pick a shift form or a bit index, and the low three bits name the operand register. The surrounding datapath fetches the operand, presents it with the current flags, and receives the result, a write-back strobe, the register index and the new flags one clock later.

Eight shift-type forms are covered: circular rotates, rotates through carry, a left shift, arithmetic and logical right shifts, and a nibble swap. Three single-bit forms are also covered: test, clear and set. The write-back strobe tells the register file or memory stage whether the result must be stored. It is low for a bit test, which only affects flags.

Top module: `xbit_unit`

## Requirements
- R1: Opcode fields are group = bits 7:6, select = bits 5:3, register = bits 2:0. A request accepted with `in_valid` high yields `out_valid` high exactly one clock later, with `reg_sel` equal to the register field. `wr_en` is never high without `out_valid`.
- R2: With group 0, select 0 rotates left circularly: the old bit 7 goes to both carry and bit 0. Select 1 rotates right circularly: the old bit 0 goes to both carry and bit 7.
- R3: With group 0, select 2 rotates left through carry and select 3 rotates right through carry. The bit shifted out goes to carry, and the incoming carry fills the vacated bit.
- R4: With group 0, select 4 shifts left, moving bit 7 to carry and filling bit 0 with 0. Select 7 shifts right logically, moving bit 0 to carry and filling bit 7 with 0.
- R5: With group 0, select 5 shifts right arithmetically: bit 0 goes to carry and bit 7 keeps its value.
- R6: With group 0, select 6 exchanges the upper and lower nibbles and clears carry.
- R7: Flags are a 4-bit vector {zero, subtract, half-carry, carry}, with zero at bit 3 and carry at bit 0. For every group-0 form, `wr_en` is 1, zero is set exactly when the result is 0, and subtract and half-carry are cleared.
- R8: Group 1 tests bit `select` of the operand. `wr_en` is 0, zero becomes the inverse of the tested bit, subtract is cleared, half-carry is set, and carry keeps its incoming value.
- R9: Group 2 clears bit `select` and group 3 sets bit `select`. Every other bit is unchanged, `wr_en` is 1, and all four flags equal the incoming flags.
- R10: After reset, `out_valid`, `wr_en`, `result`, `flags_out` and `reg_sel` are all 0. A clock with `in_valid` low gives `out_valid` and `wr_en` of 0 and leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Opcode, operand and flags are valid this cycle |
| opcode | input | 8 | Prefixed opcode byte |
| operand | input | DATA_W | Operand byte |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| out_valid | output | 1 | Result and flags are valid |
| wr_en | output | 1 | Result must be written back |
| reg_sel | output | 3 | Register field of the opcode |
| result | output | DATA_W | Operation result |
| flags_out | output | 4 | New flags {Z,N,H,C} |

## Verification
Every output of this unit is due exactly one clock after the request is sampled. This holds for the result, the write-back strobe, the register index and the flags, whatever the operation group. The bench drives each request on a falling edge and checks all five outputs together on the next falling edge, so exactly one rising edge separates stimulus from check. The idle and reset checks are also read on a falling edge, one edge after the condition they test.

// File: rtl/xbit_pkg.sv
// Package: shared types for the prefixed bit/shift execution unit.
// Assumes an 8-bit opcode with fields group[7:6], select[5:3], reg[2:0].
package xbit_pkg;

    typedef enum logic [2:0] {
        SH_ROL_CIRC  = 3'd0,
        SH_ROR_CIRC  = 3'd1,
        SH_ROL_CARRY = 3'd2,
        SH_ROR_CARRY = 3'd3,
        SH_SHL       = 3'd4,
        SH_SHR_ARITH = 3'd5,
        SH_NIB_SWAP  = 3'd6,
        SH_SHR_LOGIC = 3'd7
    } shift_kind_e;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLEAR = 2'd2,
        GRP_SET   = 2'd3
    } group_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        group_e     grp;
        logic [2:0] sel;
        logic [2:0] reg_idx;
    } dec_t;

endpackage

// File: rtl/xbit_decode.sv
// Module: xbit_decode
// Splits the prefixed opcode byte into group, select and register fields.
// Assumes the opcode is a full 8-bit byte; purely combinational.
module xbit_decode
    import xbit_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    // Field extraction from fixed bit positions.
    always_comb begin
        dec.grp     = group_e'(opcode[7:6]);
        dec.sel     = opcode[5:3];
        dec.reg_idx = opcode[2:0];
    end
endmodule

// File: rtl/xbit_shifter.sv
// Module: xbit_shifter
// Computes the eight rotate/shift/swap forms and the carry they produce.
// Assumes DATA_W is even (nibble swap splits the word in halves).
module xbit_shifter
    import xbit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] din,
    input  logic              carry_in,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] dout,
    output logic              carry_out
);
    localparam int MSB   = DATA_W - 1;
    localparam int HALF  = DATA_W / 2;

    // Select the shifted word and the bit that leaves it.
    always_comb begin
        unique case (kind)
            SH_ROL_CIRC: begin
                dout      = {din[MSB-1:0], din[MSB]};
                carry_out = din[MSB];
            end
            SH_ROR_CIRC: begin
                dout      = {din[0], din[MSB:1]};
                carry_out = din[0];
            end
            SH_ROL_CARRY: begin
                dout      = {din[MSB-1:0], carry_in};
                carry_out = din[MSB];
            end
            SH_ROR_CARRY: begin
                dout      = {carry_in, din[MSB:1]};
                carry_out = din[0];
            end
            SH_SHL: begin
                dout      = {din[MSB-1:0], 1'b0};
                carry_out = din[MSB];
            end
            SH_SHR_ARITH: begin
                dout      = {din[MSB], din[MSB:1]};
                carry_out = din[0];
            end
            SH_NIB_SWAP: begin
                dout      = {din[HALF-1:0], din[MSB:HALF]};
                carry_out = 1'b0;
            end
            default: begin
                dout      = {1'b0, din[MSB:1]};
                carry_out = din[0];
            end
        endcase
    end
endmodule

// File: rtl/xbit_bitop.sv
// Module: xbit_bitop
// Single-bit test, clear and set on the operand at the selected index.
// Assumes the index width covers DATA_W bits; test returns the operand unchanged.
module xbit_bitop
    import xbit_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]  idx,
    input  group_e            grp,
    output logic [DATA_W-1:0] dout,
    output logic              tested
);
    logic [DATA_W-1:0] mask;

    // One-hot mask, one comparator per bit position.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (idx == IDX_W'(i));
    end

    // Apply the mask according to the group.
    always_comb begin
        tested = |(din & mask);
        unique case (grp)
            GRP_SET:   dout = din | mask;
            GRP_CLEAR: dout = din & ~mask;
            default:   dout = din;
        endcase
    end
endmodule

// File: rtl/xbit_unit.sv
// Module: xbit_unit (top)
// Executes one prefixed bit/shift opcode per accepted request; all outputs
// are registered and appear one clock after in_valid. Assumes the operand
// has already been fetched by the caller. Synchronous active-low reset.
module xbit_unit
    import xbit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] operand,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic              wr_en,
    output logic [2:0]        reg_sel,
    output logic [DATA_W-1:0] result,
    output logic [3:0]        flags_out
);
    localparam int IDX_W = $clog2(DATA_W);

    dec_t              dec;
    flags_t            fin;
    logic [DATA_W-1:0] sh_res;
    logic              sh_carry;
    logic [DATA_W-1:0] bit_res;
    logic              bit_tested;
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_wr;
    flags_t            nxt_flags;

    assign fin = flags_t'(flags_in);

    xbit_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    xbit_shifter #(.DATA_W(DATA_W)) u_shift (
        .din       (operand),
        .carry_in  (fin.c),
        .kind      (shift_kind_e'(dec.sel)),
        .dout      (sh_res),
        .carry_out (sh_carry)
    );

    xbit_bitop #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bit (
        .din    (operand),
        .idx    (IDX_W'(dec.sel)),
        .grp    (dec.grp),
        .dout   (bit_res),
        .tested (bit_tested)
    );

    // Merge group results into the next result, strobe and flags.
    always_comb begin
        nxt_res   = bit_res;
        nxt_wr    = 1'b1;
        nxt_flags = fin;
        unique case (dec.grp)
            GRP_SHIFT: begin
                nxt_res   = sh_res;
                nxt_flags = '{z: (sh_res == '0), n: 1'b0, h: 1'b0, c: sh_carry};
            end
            GRP_TEST: begin
                nxt_wr    = 1'b0;
                nxt_flags = '{z: ~bit_tested, n: 1'b0, h: 1'b1, c: fin.c};
            end
            default: ;
        endcase
    end

    // Output register; idle cycles drop valid and strobe, hold the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            reg_sel   <= '0;
            result    <= '0;
            flags_out <= '0;
        end else if (in_valid) begin
            out_valid <= 1'b1;
            wr_en     <= nxt_wr;
            reg_sel   <= dec.reg_idx;
            result    <= nxt_res;
            flags_out <= nxt_flags;
        end else begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
        end
    end
endmodule

// File: rtl/xbit_unit_chk.sv
// Module: xbit_unit_chk
// Protocol and flag checker for xbit_unit, attached by bind below.
// Assumes DATA_W = 8 for the nibble-swap property.
module xbit_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        opcode,
    input logic [DATA_W-1:0] operand,
    input logic [3:0]        flags_in,
    input logic              out_valid,
    input logic              wr_en,
    input logic [2:0]        reg_sel,
    input logic [DATA_W-1:0] result,
    input logic [3:0]        flags_out
);
    localparam int HALF = DATA_W / 2;

    logic past_ok;

    // Marks that one full clock has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_strobe_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> out_valid);

    p_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (out_valid == $past(in_valid)));

    p_reg_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && out_valid) |-> (reg_sel == $past(opcode[2:0])));

    p_shift_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid) && ($past(opcode[7:6]) == 2'b00))
        |-> (wr_en && (flags_out[3] == (result == '0)) && !flags_out[2] && !flags_out[1]));

    p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid) && ($past(opcode[7:3]) == 5'b00110))
        |-> ((result == {$past(operand[HALF-1:0]), $past(operand[DATA_W-1:HALF])}) && !flags_out[0]));

    p_test_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid) && ($past(opcode[7:6]) == 2'b01))
        |-> (!wr_en && !flags_out[2] && flags_out[1] && (flags_out[0] == $past(flags_in[0]))));

    p_keep_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid) && $past(opcode[7]))
        |-> (wr_en && (flags_out == $past(flags_in))));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(in_valid)) |-> (!wr_en && $stable(result)));
endmodule

bind xbit_unit xbit_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .operand   (operand),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .reg_sel   (reg_sel),
    .result    (result),
    .flags_out (flags_out)
);

// File: tb/tb_xbit_unit.sv
// Bench for xbit_unit: a vector table walked by one loop, then directed
// reset and idle checks. Inputs change on falling edges, outputs are read
// on the next falling edge (one rising edge of latency).
module tb_xbit_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] opcode = '0;
    logic [7:0] operand = '0;
    logic [3:0] flags_in = '0;
    logic       out_valid, wr_en;
    logic [2:0] reg_sel;
    logic [7:0] result;
    logic [3:0] flags_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    xbit_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .operand(operand), .flags_in(flags_in), .out_valid(out_valid),
        .wr_en(wr_en), .reg_sel(reg_sel), .result(result), .flags_out(flags_out)
    );

    // {opcode, operand, flags_in, exp_result, exp_wr, exp_flags}; flags {Z,N,H,C}
    localparam int NV = 16;
    localparam logic [32:0] VEC [NV] = '{
        {8'h00, 8'h85, 4'b0000, 8'h0B, 1'b1, 4'b0001}, // R2 rotate left circular
        {8'h09, 8'h01, 4'b0000, 8'h80, 1'b1, 4'b0001}, // R2 rotate right circular
        {8'h12, 8'h80, 4'b0001, 8'h01, 1'b1, 4'b0001}, // R3 rotate left via carry, cin=1
        {8'h13, 8'h80, 4'b0000, 8'h00, 1'b1, 4'b1001}, // R3 rotate left via carry, zero result
        {8'h1C, 8'h01, 4'b0001, 8'h80, 1'b1, 4'b0001}, // R3 rotate right via carry
        {8'h25, 8'hC3, 4'b1111, 8'h86, 1'b1, 4'b0001}, // R4 shift left, N/H cleared (R7)
        {8'h27, 8'h80, 4'b0000, 8'h00, 1'b1, 4'b1001}, // R4 shift left to zero (R7)
        {8'h2E, 8'h81, 4'b0000, 8'hC0, 1'b1, 4'b0001}, // R5 arithmetic right keeps bit 7
        {8'h37, 8'hA5, 4'b0001, 8'h5A, 1'b1, 4'b0000}, // R6 swap clears carry
        {8'h30, 8'h00, 4'b0111, 8'h00, 1'b1, 4'b1000}, // R6 swap of zero (R7)
        {8'h39, 8'h81, 4'b0000, 8'h40, 1'b1, 4'b0001}, // R4 logical right
        {8'h3A, 8'h01, 4'b0000, 8'h00, 1'b1, 4'b1001}, // R4 logical right to zero
        {8'h7B, 8'h80, 4'b0101, 8'h80, 1'b0, 4'b0011}, // R8 test bit 7 set, carry kept
        {8'h5C, 8'hF7, 4'b0000, 8'hF7, 1'b0, 4'b1010}, // R8 test bit 3 clear
        {8'h85, 8'hFF, 4'b1010, 8'hFE, 1'b1, 4'b1010}, // R9 clear bit 0, flags kept
        {8'hF6, 8'h00, 4'b0101, 8'h40, 1'b1, 4'b0101}  // R9 set bit 6, flags kept
    };
    localparam int VREQ [NV] = '{2, 2, 3, 3, 3, 4, 4, 5, 6, 6, 4, 4, 8, 8, 9, 9};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset", {21'd0, out_valid, wr_en, reg_sel, flags_out, 2'b0}, 32'd0);
        check("R10 reset result", {24'd0, result}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            opcode   = VEC[i][32:25];
            operand  = VEC[i][24:17];
            flags_in = VEC[i][16:13];
            @(negedge clk);
            // R1 latency, register field; then per-form expectations
            check($sformatf("R1/R%0d vec%0d", VREQ[i], i),
                  {15'd0, out_valid, reg_sel, result, wr_en, flags_out},
                  {15'd0, 1'b1, VEC[i][27:25], VEC[i][12:0]});
        end

        // R10 idle cycle: no valid, no strobe, result held
        held = result;
        in_valid = 1'b0;
        opcode   = 8'hC7;
        operand  = 8'h00;
        @(negedge clk);
        check("R10 idle", {30'd0, out_valid, wr_en}, 32'd0);
        check("R10 idle hold", {24'd0, result}, {24'd0, held});

        // R1 back-to-back: strobe follows each request independently
        in_valid = 1'b1; opcode = 8'h41; operand = 8'h01; flags_in = 4'b0000;
        @(negedge clk);
        check("R8 test bit0 set", {27'd0, wr_en, flags_out}, {27'd0, 1'b0, 4'b0010});
        opcode = 8'h00; operand = 8'h00;
        @(negedge clk);
        check("R2 rotate zero", {19'd0, wr_en, flags_out, result}, {19'd0, 1'b1, 4'b1000, 8'h00});

        // R10 reset mid-stream clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 re-reset", {16'd0, out_valid, wr_en, reg_sel, flags_out, result[6:0]}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule